// File: doc/BRIEF.md
# Indirect SerDes Register Access Master

This block performs one read or one write at a time into the control register space of a SerDes. That space cannot be reached directly. Each register touch first writes a page-select word into a window register belonging to the chosen PHY, and only then accesses a slot inside that window. On top of this window sits a second layer of indirection: the SerDes exposes a control register, an address register and a data register. A transfer into the real register space is therefore a short sequence of commands. The sequence waits for the busy bit to clear, loads the target address, and then either starts a read and collects the data or loads write data and starts a write.

A client presents a request with a direction, a PHY index, a 16-bit SerDes register address and 16-bit write data. The block answers with a one-cycle response strobe carrying the read data. On the other side it drives a plain memory-mapped master port that uses a request/acknowledge handshake. Busy polls are spaced by a fixed back-off. A poll budget prevents the block from hanging on a SerDes that never goes idle. When the budget runs out, the request ends early and a sticky flag records the event.

Top module: `serdes_reg_master`

## Requirements
- R1: `req_ready` is high only while the block is idle; a request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_valid` has no effect at any other time.
- R2: Every bus access to a SerDes register is immediately preceded by a write of the page word `(dev << 7) | addr[15:9]` to address `BASE + 0x1000*phy + 0x800`, where `BASE` is 0xFFF58000.
- R3: The register access itself goes to `BASE + 0x1000*phy` OR `(addr[8:0] << 2)`. The `dev` used in the page word is 31 when `phy` is 5 and 5 for every other PHY. The control register sits at 0x80A0, the address register at 0x80A1 and the data register at 0x80A2.
- R4: A read makes the following accesses in order: it polls the control register until bit 0 (busy) reads 0, writes the target address to the address register, writes 0x1 to the control register, polls busy again, and finally reads the data register.
- R5: A write makes the following accesses in order: it polls busy until clear, writes the address register, writes the data register, and writes 0x3 to the control register (bit 0 start, bit 1 write). It does not poll after the start.
- R6: After a poll that returns busy, `m_req` stays low for exactly `BACKOFF` cycles (default 4) before the page write of the next poll.
- R7: If `POLL_LIMIT` consecutive polls (default 8) in one wait all return busy, the request ends with no further bus access. The response then returns data 0, and `timeout_flag` is set and stays set until reset.
- R8: Each request produces exactly one `rsp_valid` pulse, one cycle wide. Its `rsp_rdata` is bits 15:0 of the data register word for a completed read, and 0 for a write.
- R9: After reset, `req_ready` is 1 and `m_req`, `rsp_valid` and `timeout_flag` are 0.
- R10: While `m_req` is high and `m_ack` has not been seen, `m_addr`, `m_we` and `m_wdata` hold their values. Each acknowledge completes exactly one access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Client request strobe |
| req_ready | output | 1 | Idle, a request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | PHY_W | PHY index |
| req_addr | input | RA_W | SerDes register address |
| req_wdata | input | RD_W | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_rdata | output | RD_W | Read data, 0 for writes and timeouts |
| timeout_flag | output | 1 | Sticky poll-budget exhaustion flag |
| m_req | output | 1 | Bus access request |
| m_we | output | 1 | Bus access is a write |
| m_addr | output | BA_W | Bus byte address |
| m_wdata | output | BD_W | Bus write data |
| m_ack | input | 1 | Bus access acknowledge |
| m_rdata | input | BD_W | Bus read data, valid with `m_ack` |

## Verification
A corrupted step or state register shows up on the bus within one access. The next page write or register address appears out of order or at a wrong offset, or a start word carries the wrong write bit. A miscounted poll or back-off counter shows up at the first busy poll, either as a gap of the wrong length on `m_req` or as a timeout one poll too early or too late. A bad captured request field, such as the PHY, the address or the data, surfaces in the very first page-write word, in the access address, or in the returned read data.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MAP,
    ST_ACC,
    ST_WAIT
  } state_e;

  typedef enum logic [2:0] {
    SP_POLL_A,
    SP_SET_ADDR,
    SP_SET_DATA,
    SP_KICK,
    SP_POLL_B,
    SP_FETCH
  } step_e;

  localparam logic [15:0] CTL_REG  = 16'h80A0;
  localparam logic [15:0] ADDR_REG = 16'h80A1;
  localparam logic [15:0] DATA_REG = 16'h80A2;
  localparam int BUSY_BIT  = 0;
  localparam int WRITE_BIT = 1;

  function automatic logic [15:0] reg_of(step_e s);
    case (s)
      SP_SET_ADDR:          return ADDR_REG;
      SP_SET_DATA, SP_FETCH: return DATA_REG;
      default:              return CTL_REG;
    endcase
  endfunction

  function automatic logic step_writes(step_e s);
    return (s == SP_SET_ADDR) || (s == SP_SET_DATA) || (s == SP_KICK);
  endfunction

endpackage

// File: rtl/sra_addr_map.sv
module sra_addr_map #(
  parameter int PHY_W = 3,
  parameter int RA_W  = 16,
  parameter int BA_W  = 32,
  parameter int BD_W  = 32,
  parameter logic [BA_W-1:0] BASE_ADDR  = BA_W'(32'hFFF5_8000),
  parameter logic [BA_W-1:0] PHY_STRIDE = BA_W'(32'h0000_1000),
  parameter logic [BA_W-1:0] WIN_OFF    = BA_W'(32'h0000_0800),
  parameter int ALT_PHY  = 5,
  parameter int LANE_DEV = 5,
  parameter int ALT_DEV  = 31,
  parameter int DEV_W    = 5,
  parameter int WIN_AW   = 9
) (
  input  logic [PHY_W-1:0] phy,
  input  logic [RA_W-1:0]  reg_addr,
  output logic [BA_W-1:0]  map_addr,
  output logic [BD_W-1:0]  map_word,
  output logic [BA_W-1:0]  acc_addr
);
  localparam int PAGE_W = RA_W - WIN_AW;

  logic [BA_W-1:0]   phy_base;
  logic [DEV_W-1:0]  dev;
  logic [PAGE_W-1:0] page;

  assign phy_base = BASE_ADDR + (BA_W'(phy) * PHY_STRIDE);
  assign dev      = (phy == PHY_W'(ALT_PHY)) ? DEV_W'(ALT_DEV) : DEV_W'(LANE_DEV);
  assign page     = reg_addr[RA_W-1:WIN_AW];
  assign map_addr = phy_base + WIN_OFF;
  assign map_word = BD_W'({dev, page});
  assign acc_addr = phy_base | (BA_W'(reg_addr[WIN_AW-1:0]) << 2);

endmodule

// File: rtl/sra_poll_counter.sv
module sra_poll_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic hit,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (hit)   cnt_q <= cnt_q + CW'(1);
  end

  assign last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/sra_backoff.sv
module sra_backoff #(
  parameter int CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic expired
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= CW'(CYCLES - 1);
    else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/serdes_reg_master.sv
module serdes_reg_master
  import sra_pkg::*;
#(
  parameter int PHY_W = 3,
  parameter int RA_W  = 16,
  parameter int RD_W  = 16,
  parameter int BA_W  = 32,
  parameter int BD_W  = 32,
  parameter logic [BA_W-1:0] BASE_ADDR  = BA_W'(32'hFFF5_8000),
  parameter logic [BA_W-1:0] PHY_STRIDE = BA_W'(32'h0000_1000),
  parameter logic [BA_W-1:0] WIN_OFF    = BA_W'(32'h0000_0800),
  parameter int ALT_PHY    = 5,
  parameter int LANE_DEV   = 5,
  parameter int ALT_DEV    = 31,
  parameter int BACKOFF    = 4,
  parameter int POLL_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [PHY_W-1:0] req_phy,
  input  logic [RA_W-1:0]  req_addr,
  input  logic [RD_W-1:0]  req_wdata,
  output logic             rsp_valid,
  output logic [RD_W-1:0]  rsp_rdata,
  output logic             timeout_flag,
  output logic             m_req,
  output logic             m_we,
  output logic [BA_W-1:0]  m_addr,
  output logic [BD_W-1:0]  m_wdata,
  input  logic             m_ack,
  input  logic [BD_W-1:0]  m_rdata
);

  initial begin
    if (BACKOFF < 1 || POLL_LIMIT < 1 || RA_W < 10) $error("bad parameters");
  end

  state_e st_q, st_d;
  step_e  step_q, step_d, issue_sp;
  logic   issue;

  logic             wr_q;
  logic [PHY_W-1:0] phy_q, phy_sel;
  logic [RA_W-1:0]  addr_q;
  logic [RD_W-1:0]  wdata_q;
  logic             capture;

  logic             m_req_d, m_we_d, rsp_v_d, to_d, rdy_d;
  logic [BA_W-1:0]  m_addr_d;
  logic [BD_W-1:0]  m_wdata_d, acc_wdata;
  logic [RD_W-1:0]  rsp_d;

  logic [RA_W-1:0]  tgt_reg;
  logic [BA_W-1:0]  map_addr, acc_addr;
  logic [BD_W-1:0]  map_word;

  logic poll_clr, poll_hit, poll_last;
  logic wait_load, wait_done;

  assign phy_sel = (st_q == ST_IDLE) ? req_phy : phy_q;
  assign tgt_reg = issue ? RA_W'(reg_of(issue_sp)) : RA_W'(reg_of(step_q));

  sra_addr_map #(
    .PHY_W(PHY_W), .RA_W(RA_W), .BA_W(BA_W), .BD_W(BD_W),
    .BASE_ADDR(BASE_ADDR), .PHY_STRIDE(PHY_STRIDE), .WIN_OFF(WIN_OFF),
    .ALT_PHY(ALT_PHY), .LANE_DEV(LANE_DEV), .ALT_DEV(ALT_DEV)
  ) u_map (
    .phy(phy_sel), .reg_addr(tgt_reg),
    .map_addr(map_addr), .map_word(map_word), .acc_addr(acc_addr)
  );

  sra_poll_counter #(.LIMIT(POLL_LIMIT)) u_polls (
    .clk(clk), .rst(rst), .clr(poll_clr), .hit(poll_hit), .last(poll_last)
  );

  sra_backoff #(.CYCLES(BACKOFF)) u_backoff (
    .clk(clk), .rst(rst), .load(wait_load), .expired(wait_done)
  );

  always_comb begin
    acc_wdata = '0;
    case (step_q)
      SP_SET_ADDR: acc_wdata = BD_W'(addr_q);
      SP_SET_DATA: acc_wdata = BD_W'(wdata_q);
      SP_KICK:     acc_wdata = (BD_W'(1) << BUSY_BIT) | (BD_W'(wr_q) << WRITE_BIT);
      default:     acc_wdata = '0;
    endcase
  end

  always_comb begin
    st_d      = st_q;
    step_d    = step_q;
    issue     = 1'b0;
    issue_sp  = step_q;
    capture   = 1'b0;
    poll_clr  = 1'b0;
    poll_hit  = 1'b0;
    wait_load = 1'b0;
    m_req_d   = m_req;
    m_we_d    = m_we;
    m_addr_d  = m_addr;
    m_wdata_d = m_wdata;
    rsp_v_d   = 1'b0;
    rsp_d     = rsp_rdata;
    to_d      = timeout_flag;

    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          capture  = 1'b1;
          poll_clr = 1'b1;
          issue    = 1'b1;
          issue_sp = SP_POLL_A;
        end
      end
      ST_MAP: begin
        if (m_ack) begin
          st_d      = ST_ACC;
          m_we_d    = step_writes(step_q);
          m_addr_d  = acc_addr;
          m_wdata_d = acc_wdata;
        end
      end
      ST_ACC: begin
        if (m_ack) begin
          case (step_q)
            SP_POLL_A, SP_POLL_B: begin
              if (m_rdata[BUSY_BIT]) begin
                poll_hit = 1'b1;
                m_req_d  = 1'b0;
                if (poll_last) begin
                  to_d    = 1'b1;
                  rsp_v_d = 1'b1;
                  rsp_d   = '0;
                  st_d    = ST_IDLE;
                end else begin
                  wait_load = 1'b1;
                  st_d      = ST_WAIT;
                end
              end else begin
                poll_clr = 1'b1;
                issue    = 1'b1;
                issue_sp = (step_q == SP_POLL_A) ? SP_SET_ADDR : SP_FETCH;
              end
            end
            SP_SET_ADDR: begin
              issue    = 1'b1;
              issue_sp = wr_q ? SP_SET_DATA : SP_KICK;
            end
            SP_SET_DATA: begin
              issue    = 1'b1;
              issue_sp = SP_KICK;
            end
            SP_KICK: begin
              if (wr_q) begin
                m_req_d = 1'b0;
                rsp_v_d = 1'b1;
                rsp_d   = '0;
                st_d    = ST_IDLE;
              end else begin
                issue    = 1'b1;
                issue_sp = SP_POLL_B;
              end
            end
            default: begin
              m_req_d = 1'b0;
              rsp_v_d = 1'b1;
              rsp_d   = m_rdata[RD_W-1:0];
              st_d    = ST_IDLE;
            end
          endcase
        end
      end
      default: begin
        if (wait_done) begin
          issue    = 1'b1;
          issue_sp = step_q;
        end
      end
    endcase

    if (issue) begin
      st_d      = ST_MAP;
      step_d    = issue_sp;
      m_req_d   = 1'b1;
      m_we_d    = 1'b1;
      m_addr_d  = map_addr;
      m_wdata_d = map_word;
    end
    rdy_d = (st_d == ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      step_q       <= SP_POLL_A;
      wr_q         <= 1'b0;
      phy_q        <= '0;
      addr_q       <= '0;
      wdata_q      <= '0;
      req_ready    <= 1'b1;
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      timeout_flag <= 1'b0;
      m_req        <= 1'b0;
      m_we         <= 1'b0;
      m_addr       <= '0;
      m_wdata      <= '0;
    end else begin
      st_q         <= st_d;
      step_q       <= step_d;
      req_ready    <= rdy_d;
      rsp_valid    <= rsp_v_d;
      rsp_rdata    <= rsp_d;
      timeout_flag <= to_d;
      m_req        <= m_req_d;
      m_we         <= m_we_d;
      m_addr       <= m_addr_d;
      m_wdata      <= m_wdata_d;
      if (capture) begin
        wr_q    <= req_write;
        phy_q   <= req_phy;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

endmodule

// File: rtl/sra_checker.sv
module sra_checker #(
  parameter int BA_W = 32,
  parameter int BD_W = 32,
  parameter logic [BA_W-1:0] PHY_STRIDE = BA_W'(32'h0000_1000),
  parameter logic [BA_W-1:0] WIN_OFF    = BA_W'(32'h0000_0800)
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            timeout_flag,
  input logic            m_req,
  input logic            m_we,
  input logic [BA_W-1:0] m_addr,
  input logic [BD_W-1:0] m_wdata,
  input logic            m_ack
);

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (rst)
    m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)); // R10

  AST_NO_READY_ON_BUS: assert property (@(posedge clk) disable iff (rst)
    m_req |-> !req_ready); // R1

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready |=> !req_ready); // R1

  AST_WINDOW_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    m_req && ((m_addr & (PHY_STRIDE - BA_W'(1))) == WIN_OFF) |-> m_we); // R2

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R8

  AST_RSP_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !m_req); // R8

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (rst)
    timeout_flag |=> timeout_flag); // R7

endmodule

bind serdes_reg_master sra_checker #(
  .BA_W(BA_W), .BD_W(BD_W), .PHY_STRIDE(PHY_STRIDE), .WIN_OFF(WIN_OFF)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .timeout_flag(timeout_flag), .m_req(m_req),
  .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_ack(m_ack)
);

// File: tb/serdes_reg_master_test.sv
module serdes_reg_master_test;
  localparam logic [31:0] BASE = 32'hFFF5_8000;
  localparam int B   = 4;
  localparam int LIM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [2:0] req_phy = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic req_ready, rsp_valid, timeout_flag, m_req, m_we;
  logic [15:0] rsp_rdata;
  logic [31:0] m_addr, m_wdata;
  logic m_ack = 1'b0;
  logic [31:0] m_rdata = '0;

  always #2.5 clk = ~clk;

  serdes_reg_master uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_phy(req_phy), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .timeout_flag(timeout_flag), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_ack(m_ack), .m_rdata(m_rdata)
  );

  int total = 0, fails = 0;

  // bench-side SerDes model and transaction log
  int busy_left = 0, busy_after = 0, lat = 0;
  logic [15:0] map_q = '0, tgt_q = '0;
  int lg_n = 0;
  logic [31:0] lg_addr [0:63];
  logic        lg_we   [0:63];
  logic [31:0] lg_wd   [0:63];
  int          lg_gap  [0:63];
  bit stable_bad = 0;

  int ex_n = 0;
  logic [31:0] ex_addr [0:63];
  logic        ex_we   [0:63];
  logic [31:0] ex_wd   [0:63];
  int          ex_gap  [0:63];
  bit          ex_map  [0:63];

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  initial begin : slave
    int low_cnt, lat_cnt, cur_gap, ph;
    logic [31:0] off, sa, sw;
    logic [15:0] r16;
    logic swe;
    low_cnt = 0; lat_cnt = 0; cur_gap = 0;
    forever begin
      @(negedge clk);
      if (!m_req) low_cnt++;
      if (m_ack) begin
        m_ack = 1'b0;
      end else if (m_req) begin
        if (lat_cnt == 0) begin
          cur_gap = low_cnt; low_cnt = 0;
          sa = m_addr; sw = m_wdata; swe = m_we;
        end else if (sa !== m_addr || sw !== m_wdata || swe !== m_we) begin
          stable_bad = 1;
        end
        if (lat_cnt < lat) lat_cnt++;
        else begin
          lat_cnt = 0;
          ph  = int'((m_addr - BASE) >> 12);
          off = m_addr & 32'hFFF;
          m_rdata = 32'h0;
          if (off == 32'h800) begin
            if (m_we) map_q = m_wdata[15:0];
          end else begin
            r16 = {map_q[6:0], off[10:2]};
            if (r16 == 16'h80A0) begin
              if (m_we) begin
                if (m_wdata[0]) busy_left = busy_after;
              end else if (busy_left > 0) begin
                m_rdata = 32'hFFFF_0001; busy_left--;
              end else m_rdata = 32'hFFFF_0000;
            end else if (r16 == 16'h80A1 && m_we) tgt_q = m_wdata[15:0];
            else if (r16 == 16'h80A2 && !m_we)
              m_rdata = {16'hBEEF, tgt_q ^ 16'h5A3C ^ 16'(ph)};
          end
          if (lg_n < 64) begin
            lg_addr[lg_n] = m_addr; lg_we[lg_n] = m_we;
            lg_wd[lg_n] = m_wdata; lg_gap[lg_n] = cur_gap;
            lg_n++;
          end
          m_ack = 1'b1;
        end
      end
    end
  end

  task automatic push(logic [31:0] a, logic we, logic [31:0] wd, int gap, bit mp);
    ex_addr[ex_n] = a; ex_we[ex_n] = we; ex_wd[ex_n] = wd;
    ex_gap[ex_n] = gap; ex_map[ex_n] = mp; ex_n++;
  endtask

  task automatic exp_poll(int phy, int b, int g0, output bit to);
    logic [31:0] pb = BASE + 32'h1000 * phy;
    logic [31:0] mw = ((phy == 5) ? 31 : 5) * 128 + 64;
    for (int k = 0; k <= b && k < LIM; k++) begin
      push(pb + 32'h800, 1, mw, (k == 0) ? g0 : B, 1);
      push(pb | 32'h280, 0, 0, 0, 0);
    end
    to = (b >= LIM);
  endtask

  bit sticky_exp = 0;

  task automatic run_req(bit wr, int phy, logic [15:0] a, logic [15:0] d,
                         int b1, int b2, bit spam, int l);
    logic [31:0] pb = BASE + 32'h1000 * phy;
    logic [31:0] mw = ((phy == 5) ? 31 : 5) * 128 + 64;
    logic [15:0] exp_rd, got;
    bit to, rdy_bad, ok_seq, ok_map, ok_acc, ok_gap;
    string sq;
    sq = wr ? "R5" : "R4";
    ex_n = 0;
    exp_poll(phy, b1, -1, to);
    exp_rd = 16'h0;
    if (!to) begin
      push(pb + 32'h800, 1, mw, 0, 1); push(pb | 32'h284, 1, {16'h0, a}, 0, 0);
      if (wr) begin
        push(pb + 32'h800, 1, mw, 0, 1); push(pb | 32'h288, 1, {16'h0, d}, 0, 0);
        push(pb + 32'h800, 1, mw, 0, 1); push(pb | 32'h280, 1, 32'h3, 0, 0);
      end else begin
        push(pb + 32'h800, 1, mw, 0, 1); push(pb | 32'h280, 1, 32'h1, 0, 0);
        exp_poll(phy, b2, 0, to);
        if (!to) begin
          push(pb + 32'h800, 1, mw, 0, 1); push(pb | 32'h288, 0, 0, 0, 0);
          exp_rd = a ^ 16'h5A3C ^ 16'(phy);
        end
      end
    end
    if (to) sticky_exp = 1;

    @(negedge clk);
    busy_left = b1; busy_after = b2; lat = l; lg_n = 0; stable_bad = 0;
    chk(req_ready === 1'b1, "R1", "ready before request", req_ready, 1);
    req_valid = 1; req_write = wr; req_phy = 3'(phy); req_addr = a; req_wdata = d;
    @(negedge clk);
    if (spam) begin
      req_write = ~wr; req_phy = 3'(phy ^ 1); req_addr = ~a; req_wdata = ~d;
    end else req_valid = 0;
    rdy_bad = 0;
    while (!rsp_valid) begin
      if (req_ready) rdy_bad = 1;
      @(negedge clk);
    end
    got = rsp_rdata;
    req_valid = 0;
    chk(!rdy_bad, "R1", "ready stayed low while busy", rdy_bad, 0);

    ok_seq = (lg_n == ex_n); ok_map = 1; ok_acc = 1; ok_gap = 1;
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      if (lg_we[i] !== ex_we[i] || (ex_we[i] && lg_wd[i] !== ex_wd[i])) ok_seq = 0;
      if (ex_map[i] && lg_addr[i] !== ex_addr[i]) ok_map = 0;
      if (!ex_map[i] && lg_addr[i] !== ex_addr[i]) ok_acc = 0;
      if (ex_gap[i] >= 0 && lg_gap[i] != ex_gap[i]) ok_gap = 0;
    end
    chk(ok_seq, sq, $sformatf("access order phy %0d addr %h (count)", phy, a), lg_n, ex_n);
    chk(ok_map, "R2", $sformatf("page writes phy %0d", phy), lg_n, ex_n);
    chk(ok_acc, "R3", $sformatf("register addresses phy %0d", phy), lg_n, ex_n);
    if (b1 > 0 || (!wr && b2 > 0))
      chk(ok_gap, "R6", $sformatf("back-off gap phy %0d", phy), 0, B);
    chk(!stable_bad, "R10", "bus fields held until ack", stable_bad, 0);
    chk(got === exp_rd, to ? "R7" : "R8", "response data", got, exp_rd);
    chk(timeout_flag === sticky_exp, "R7", "timeout flag", timeout_flag, sticky_exp);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R8", "response pulse one cycle", rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready === 1 && m_req === 0 && rsp_valid === 0 && timeout_flag === 0,
        "R9", "reset state", {req_ready, m_req, rsp_valid, timeout_flag}, 4'b1000);

    for (int p = 0; p < 6; p++)
      for (int w = 0; w < 2; w++)
        run_req(w[0], p, 16'h2001 + 16'(p) * 16'h0101 + 16'(w) * 16'h0700,
                16'hA5C3 ^ 16'(p * 17), p % 3, (p + w) % 3, p[0], (p + w) % 3);
    run_req(0, 5, 16'hFFFF, 16'h0, 0, 0, 0, 0);
    run_req(1, 0, 16'h0000, 16'hFFFF, 0, 0, 1, 0);
    run_req(0, 2, 16'h1234, 16'h0, LIM - 1, LIM - 1, 0, 1);
    run_req(1, 4, 16'h4321, 16'h7E7E, LIM - 1, 0, 0, 2);
    chk(timeout_flag === 0, "R7", "no timeout at budget minus one", timeout_flag, 0);
    run_req(0, 1, 16'h0F0F, 16'h0, LIM, 0, 0, 0);
    run_req(0, 3, 16'h3C3C, 16'h0, 0, LIM + 1, 1, 1);
    run_req(1, 5, 16'h5555, 16'h9999, LIM, 0, 0, 0);
    run_req(0, 0, 16'h8001, 16'h0, 1, 1, 0, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule